// File: doc/BRIEF.md
# Word-Register Bus Slave with Byte-Lane Writes

This block is a single-beat AHB-Lite slave that holds a bank of 32-bit registers. With the default parameters the bank spans 16 KB, which is 4096 registers at word-aligned addresses. The slave accepts byte, halfword and word transfers. For a write, it works out which byte lanes the transfer covers from the transfer size and the low address bits, and it updates only those lanes in the data phase. Every read returns the whole addressed register on the data bus, so the master takes the lanes it asked for.

A build parameter can switch off sub-word access. In that build, byte and halfword transfers are refused with a two-cycle ERROR response. Misaligned transfers, and transfers wider than the bus, are always refused the same way. A refused transfer never changes a register. IDLE and BUSY transfers, and cycles in which the slave is not selected, complete with a zero-wait OKAY response.

Top module: `ahb_wordreg_slave`

## Requirements
- R1: A word transfer (hsize=2) at a word-aligned address writes all four byte lanes of the register at index haddr[ADDR_W-1:2]. A later word read at the same address returns the written value.
- R2: A byte write (hsize=0) updates only byte lane haddr[1:0], where lane k is bits 8k+7:8k, taking its data from that lane of hwdata. The other three bytes of the register keep their values, whatever the other lanes of hwdata carry.
- R3: A halfword write (hsize=1) with haddr[1]=0 updates bits 15:0 only. With haddr[1]=1 it updates bits 31:16 only.
- R4: A read completes with zero wait states and an OKAY response (hresp=0). It returns the full 32-bit register on hrdata in the data-phase cycle.
- R5: Write data is taken from hwdata in the cycle after the address phase. A read issued in the address phase directly behind a write to the same register returns the newly written value.
- R6: A halfword transfer with haddr[0]=1, a word transfer with haddr[1:0]!=0, or any transfer with hsize>2 receives an ERROR response and leaves the register unchanged.
- R7: When built with SUBWORD_EN=0, byte and halfword transfers receive an ERROR response and leave the register unchanged, while word transfers behave as in R1.
- R8: An ERROR response lasts two cycles. In the first, hreadyout=0 and hresp=1. In the second, hreadyout=1 and hresp=1.
- R9: An address phase with htrans IDLE (0) or BUSY (1), or with hsel=0, starts no transfer. The following cycle shows hreadyout=1 and hresp=0, and no register changes.
- R10: After reset, hreadyout=1 and hresp=0.
- R11: Only haddr[ADDR_W-1:0] is decoded. Addresses that differ only above bit ADDR_W-1 reach the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Byte address |
| htrans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| hwrite | input | 1 | 1 for a write, 0 for a read |
| hsize | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| hwdata | input | DATA_W (32) | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready, previous transfer finished |
| hreadyout | output | 1 | This slave's ready |
| hresp | output | 1 | 0 OKAY, 1 ERROR |
| hrdata | output | DATA_W (32) | Read data, the full addressed register |

## Verification
The bench builds two copies of the slave on one shared bus.

The first copy uses the default 14 address bits with sub-word access enabled. It covers lane selection for every size and offset, back-to-back write-then-read, the misaligned and oversized refusals, and aliasing of addresses above bit 13.

The second copy uses SUBWORD_EN=0 and only 8 address bits. That build is the only way to reach the narrow-access refusal of R7, and its small bank keeps elaboration light.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;

   // Bus transfer encodings used by the slave
   localparam logic [1:0] TRANS_IDLE   = 2'b00;
   localparam logic [1:0] TRANS_BUSY   = 2'b01;
   localparam logic [1:0] TRANS_NONSEQ = 2'b10;
   localparam logic [1:0] TRANS_SEQ    = 2'b11;

   localparam logic RESP_OKAY  = 1'b0;
   localparam logic RESP_ERROR = 1'b1;

   // Data-phase response sequencing
   typedef enum logic [1:0] {
      RSP_IDLE     = 2'b00,
      RSP_ERR_HOLD = 2'b01,
      RSP_ERR_LAST = 2'b10
   } rsp_state_e;

endpackage

// File: rtl/ahbw_lane_decode.sv
module ahbw_lane_decode #(
   parameter int LANES      = 4,
   parameter bit SUBWORD_EN = 1'b1,
   localparam int LANE_BITS = $clog2(LANES)
) (
   input  logic [2:0]           size,
   input  logic [LANE_BITS-1:0] addr_lo,
   output logic [LANES-1:0]     lane_en,
   output logic                 reject
);

   logic too_wide;
   logic misaligned;
   logic narrow_bad;

   always_comb begin
      int sz;
      int off;
      sz = int'(size);
      off = int'(addr_lo);
      too_wide = (sz > LANE_BITS);
      misaligned = too_wide ? 1'b0 : ((off & ((1 << sz) - 1)) != 0);
      for (int k = 0; k < LANES; k++) begin
         lane_en[k] = !too_wide && ((k >> sz) == (off >> sz));
      end
   end

   generate
      if (SUBWORD_EN) begin : g_narrow_ok
         assign narrow_bad = 1'b0;
      end else begin : g_narrow_refused
         assign narrow_bad = (int'(size) != LANE_BITS);
      end
   endgenerate

   assign reject = too_wide | misaligned | narrow_bad;

endmodule

// File: rtl/ahbw_addr_stage.sv
module ahbw_addr_stage #(
   parameter int LANES = 4,
   parameter int IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             reject,
   input  logic             is_write,
   input  logic [2:0]       size,
   input  logic [IDX_W-1:0] index,
   input  logic [LANES-1:0] lane_en,
   output logic             wr_go,
   output logic [IDX_W-1:0] idx_q,
   output logic [LANES-1:0] lane_q
);

   localparam int LANE_BITS = $clog2(LANES);

   logic       dp_valid_q;
   logic [2:0] size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_valid_q <= 1'b0;
         wr_go      <= 1'b0;
         idx_q      <= '0;
         lane_q     <= '0;
         size_q     <= '0;
      end else begin
         dp_valid_q <= accept && !reject;
         wr_go      <= accept && !reject && is_write;
         if (accept) begin
            idx_q  <= index;
            lane_q <= lane_en;
            size_q <= size;
         end
      end
   end

   // A good byte transfer owns exactly one lane
   p_byte_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_valid_q && size_q == 3'd0) |-> $countones(lane_q) == 1);

   // A good halfword transfer owns exactly two lanes
   p_half_two_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_valid_q && size_q == 3'd1) |-> $countones(lane_q) == 2);

   // A good full-width transfer owns every lane
   p_word_all_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_valid_q && int'(size_q) == LANE_BITS) |-> (&lane_q));

endmodule

// File: rtl/ahbw_resp_ctrl.sv
module ahbw_resp_ctrl
   import ahbw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic reject,
   output logic ready,
   output logic resp
);

   rsp_state_e state_q;
   rsp_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         RSP_ERR_HOLD: state_d = RSP_ERR_LAST;
         RSP_IDLE, RSP_ERR_LAST:
            state_d = (accept && reject) ? RSP_ERR_HOLD : RSP_IDLE;
         default: state_d = RSP_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= RSP_IDLE;
      else        state_q <= state_d;
   end

   assign ready = (state_q != RSP_ERR_HOLD);
   assign resp  = (state_q == RSP_IDLE) ? RESP_OKAY : RESP_ERROR;

   // A refused transfer first stalls with ERROR
   p_err_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && reject) |=> (!ready && resp));

   // The stall cycle is followed by the releasing ERROR cycle
   p_err_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> (ready && resp));

   // No transfer started: zero-wait OKAY next
   p_idle_okay_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !accept) |=> (ready && !resp));

endmodule

// File: rtl/ahbw_reg_array.sv
module ahbw_reg_array #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 12
) (
   input  logic              clk,
   input  logic              we,
   input  logic [DATA_W/8-1:0] lane_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int LANES = DATA_W / 8;
   localparam int DEPTH = 1 << IDX_W;

   genvar l;
   generate
      for (l = 0; l < LANES; l++) begin : g_lane
         logic [7:0] store [DEPTH];

         always_ff @(posedge clk) begin
            if (we && lane_en[l]) store[idx] <= wdata[8*l +: 8];
         end

         assign rdata[8*l +: 8] = store[idx];
      end
   endgenerate

endmodule

// File: rtl/ahb_wordreg_slave.sv
module ahb_wordreg_slave
   import ahbw_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 14,
   parameter bit SUBWORD_EN = 1'b1
) (
   input  logic              hclk,
   input  logic              hresetn,
   input  logic              hsel,
   input  logic [31:0]       haddr,
   input  logic [1:0]        htrans,
   input  logic              hwrite,
   input  logic [2:0]        hsize,
   input  logic [DATA_W-1:0] hwdata,
   input  logic              hready,
   output logic              hreadyout,
   output logic              hresp,
   output logic [DATA_W-1:0] hrdata
);

   localparam int LANES     = DATA_W / 8;
   localparam int LANE_BITS = $clog2(LANES);
   localparam int IDX_W     = ADDR_W - LANE_BITS;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0 || (LANES & (LANES - 1)) != 0) begin : g_bad_width
         $error("DATA_W must be a power-of-two count of bytes");
      end
      if (ADDR_W <= LANE_BITS || ADDR_W >= 32) begin : g_bad_addr
         $error("ADDR_W must exceed the lane offset bits and stay below 32");
      end
   endgenerate

   logic             accept;
   logic             reject;
   logic [LANES-1:0] lane_en;
   logic             wr_go;
   logic [IDX_W-1:0] idx_q;
   logic [LANES-1:0] lane_q;
   logic             unused_bits;

   assign unused_bits = ^{haddr[31:ADDR_W], htrans[0]};

   assign accept = hsel && hready && hreadyout && htrans[1];

   ahbw_lane_decode #(
      .LANES      (LANES),
      .SUBWORD_EN (SUBWORD_EN)
   ) i_lane_decode (
      .size    (hsize),
      .addr_lo (haddr[LANE_BITS-1:0]),
      .lane_en (lane_en),
      .reject  (reject)
   );

   ahbw_addr_stage #(
      .LANES (LANES),
      .IDX_W (IDX_W)
   ) i_addr_stage (
      .clk      (hclk),
      .rst_n    (hresetn),
      .accept   (accept),
      .reject   (reject),
      .is_write (hwrite),
      .size     (hsize),
      .index    (haddr[ADDR_W-1:LANE_BITS]),
      .lane_en  (lane_en),
      .wr_go    (wr_go),
      .idx_q    (idx_q),
      .lane_q   (lane_q)
   );

   ahbw_resp_ctrl i_resp_ctrl (
      .clk    (hclk),
      .rst_n  (hresetn),
      .accept (accept),
      .reject (reject),
      .ready  (hreadyout),
      .resp   (hresp)
   );

   ahbw_reg_array #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) i_reg_array (
      .clk     (hclk),
      .we      (wr_go),
      .lane_en (lane_q),
      .idx     (idx_q),
      .wdata   (hwdata),
      .rdata   (hrdata)
   );

   // A register never changes while an ERROR is on the bus
   p_no_write_on_err_r6: assert property (@(posedge hclk) disable iff (!hresetn)
      hresp |-> !wr_go);

   // A write only follows an accepted address phase
   p_write_after_accept_r5: assert property (@(posedge hclk) disable iff (!hresetn)
      !accept |=> !wr_go);

endmodule

// File: tb/test_ahb_wordreg_slave.sv
module test_ahb_wordreg_slave;

   typedef struct {
      bit          rd;
      bit          err;
      logic [31:0] data;
      string       req;
   } exp_t;

   logic        hclk = 1'b0;
   logic        hresetn = 1'b0;
   logic        hsel = 1'b0;
   logic [31:0] haddr = '0;
   logic [1:0]  htrans = 2'b00;
   logic        hwrite = 1'b0;
   logic [2:0]  hsize = 3'd2;
   logic [31:0] hwdata = '0;
   bit          sel_b = 1'b0;

   logic        ro_a, rs_a, ro_b, rs_b;
   logic [31:0] rd_a, rd_b;
   logic        hready_m, hresp_m;
   logic [31:0] hrdata_m;

   int   checks = 0;
   int   errors = 0;
   exp_t q[$];
   bit   in_dp = 1'b0;
   int   dp_cnt = 0;
   bit   first_ok = 1'b0;

   always #4 hclk = ~hclk;

   assign hready_m = sel_b ? ro_b : ro_a;
   assign hresp_m  = sel_b ? rs_b : rs_a;
   assign hrdata_m = sel_b ? rd_b : rd_a;

   ahb_wordreg_slave i_ahb_wordreg_slave (
      .hclk (hclk), .hresetn (hresetn), .hsel (hsel && !sel_b), .haddr (haddr),
      .htrans (htrans), .hwrite (hwrite), .hsize (hsize), .hwdata (hwdata),
      .hready (hready_m), .hreadyout (ro_a), .hresp (rs_a), .hrdata (rd_a));

   ahb_wordreg_slave #(.ADDR_W (8), .SUBWORD_EN (1'b0)) i_ahb_wordreg_slave_w (
      .hclk (hclk), .hresetn (hresetn), .hsel (hsel && sel_b), .haddr (haddr),
      .htrans (htrans), .hwrite (hwrite), .hsize (hsize), .hwdata (hwdata),
      .hready (hready_m), .hreadyout (ro_b), .hresp (rs_b), .hrdata (rd_b));

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // Expected register after a write, from the lane rules of R1..R3
   function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] a,
                                         logic [2:0] s, logic [31:0] wd);
      logic [31:0] m;
      case (s)
         3'd0:    m = 32'hFF << (8 * a[1:0]);
         3'd1:    m = a[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
         default: m = 32'hFFFF_FFFF;
      endcase
      return (old & ~m) | (wd & m);
   endfunction

   // Scoreboard monitor: samples at the falling edge
   always @(negedge hclk) begin
      if (hresetn) begin
         if (in_dp) begin
            dp_cnt++;
            if (!hready_m) begin
               if (dp_cnt == 1) first_ok = hresp_m;
            end else begin
               if (q.size() == 0) begin
                  chk(1'b0, "scoreboard underflow", 32'h0, 32'h1);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  if (e.err) begin
                     chk(dp_cnt == 2 && first_ok && hresp_m, {e.req, " R8 two-cycle ERROR"},
                         {30'h0, hresp_m, first_ok}, 32'h3);
                  end else begin
                     chk(dp_cnt == 1 && !hresp_m, {e.req, " R4 zero-wait OKAY"},
                         dp_cnt, 32'h1);
                     if (e.rd) chk(hrdata_m === e.data, e.req, hrdata_m, e.data);
                  end
               end
               in_dp = 1'b0;
               dp_cnt = 0;
               first_ok = 1'b0;
            end
         end
         if (hsel && htrans[1] && hready_m) begin
            in_dp = 1'b1;
            dp_cnt = 0;
         end
      end
   end

   task automatic push(bit rd, bit err, logic [31:0] d, string req);
      exp_t e;
      e.rd = rd; e.err = err; e.data = d; e.req = req;
      q.push_back(e);
   endtask

   task automatic drain();
      while (q.size() != 0) @(posedge hclk);
   endtask

   task automatic send(bit w, logic [31:0] a, logic [2:0] s, logic [31:0] wd,
                       bit err, logic [31:0] rexp, string req);
      @(posedge hclk); #1;
      hsel = 1'b1; htrans = 2'b10; hwrite = w; haddr = a; hsize = s;
      push(!w, err, rexp, req);
      @(posedge hclk); #1;
      hsel = 1'b0; htrans = 2'b00; hwdata = wd;
      drain();
   endtask

   task automatic no_xfer(logic s_in, logic [1:0] tr, logic [31:0] a, string req);
      @(posedge hclk); #1;
      hsel = s_in; htrans = tr; hwrite = 1'b1; haddr = a; hsize = 3'd2;
      @(posedge hclk); #1;
      hsel = 1'b0; htrans = 2'b00; hwdata = 32'hDEAD_BEEF;
      @(negedge hclk);
      chk(hready_m && !hresp_m, req, {30'h0, hready_m, hresp_m}, 32'h2);
   endtask

   initial begin
      repeat (100000) @(posedge hclk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] r10;
      repeat (3) @(posedge hclk);
      @(negedge hclk);
      chk(ro_a && !rs_a, "R10 reset A", {30'h0, ro_a, rs_a}, 32'h2);
      chk(ro_b && !rs_b, "R10 reset B", {30'h0, ro_b, rs_b}, 32'h2);
      @(posedge hclk); #1;
      hresetn = 1'b1;
      @(negedge hclk);
      chk(ro_a && !rs_a, "R10 after release", {30'h0, ro_a, rs_a}, 32'h2);

      // R1: full word write and read
      r10 = 32'hA1B2_C3D4;
      send(1, 32'h10, 3'd2, r10, 0, 0, "R1 write");
      send(0, 32'h10, 3'd2, 0, 0, r10, "R1 word readback");

      // R2: byte writes with junk on the other lanes
      r10 = merge(r10, 32'h11, 3'd0, 32'hFFFF_5AFF);
      send(1, 32'h11, 3'd0, 32'hFFFF_5AFF, 0, 0, "R2 byte1 write");
      send(0, 32'h10, 3'd2, 0, 0, r10, "R2 byte lane 1");
      r10 = merge(r10, 32'h13, 3'd0, 32'h77EE_EEEE);
      send(1, 32'h13, 3'd0, 32'h77EE_EEEE, 0, 0, "R2 byte3 write");
      send(0, 32'h10, 3'd2, 0, 0, r10, "R2 byte lane 3");
      r10 = merge(r10, 32'h10, 3'd0, 32'h1111_11C9);
      send(1, 32'h10, 3'd0, 32'h1111_11C9, 0, 0, "R2 byte0 write");
      send(0, 32'h11, 3'd0, 0, 0, r10, "R2 narrow read full word R4");

      // R3: halfword writes in both halves
      r10 = merge(r10, 32'h12, 3'd1, 32'h1234_ABCD);
      send(1, 32'h12, 3'd1, 32'h1234_ABCD, 0, 0, "R3 upper half write");
      send(0, 32'h10, 3'd2, 0, 0, r10, "R3 upper half");
      r10 = merge(r10, 32'h10, 3'd1, 32'hEEEE_9876);
      send(1, 32'h10, 3'd1, 32'hEEEE_9876, 0, 0, "R3 lower half write");
      send(0, 32'h12, 3'd1, 0, 0, r10, "R3 lower half");

      // R5: back-to-back write then read of the same register
      @(posedge hclk); #1;
      hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 32'h20; hsize = 3'd2;
      push(0, 0, 0, "R5 write");
      @(posedge hclk); #1;
      htrans = 2'b11; hwrite = 1'b0; hwdata = 32'hCAFE_F00D;
      push(1, 0, 32'hCAFE_F00D, "R5 back-to-back read");
      @(posedge hclk); #1;
      hsel = 1'b0; htrans = 2'b00; hwdata = 32'h0;
      drain();

      // R6: misaligned and oversized refusals, register kept
      send(1, 32'h21, 3'd1, 32'h0000_0000, 1, 0, "R6 misaligned half");
      send(1, 32'h22, 3'd2, 32'h0000_0000, 1, 0, "R6 misaligned word");
      send(1, 32'h20, 3'd3, 32'h0000_0000, 1, 0, "R6 oversized");
      send(0, 32'h20, 3'd2, 0, 0, 32'hCAFE_F00D, "R6 register unchanged");

      // R9: BUSY, IDLE and deselected writes do nothing
      no_xfer(1'b1, 2'b01, 32'h20, "R9 BUSY okay");
      no_xfer(1'b1, 2'b00, 32'h20, "R9 IDLE okay");
      no_xfer(1'b0, 2'b10, 32'h20, "R9 deselected okay");
      send(0, 32'h20, 3'd2, 0, 0, 32'hCAFE_F00D, "R9 register unchanged");

      // R11: upper address bits alias
      send(1, 32'h0001_4024, 3'd2, 32'h55AA_33CC, 0, 0, "R11 high write");
      send(0, 32'h24, 3'd2, 0, 0, 32'h55AA_33CC, "R11 alias read");

      // R7: build without sub-word access
      @(posedge hclk); #1;
      sel_b = 1'b1;
      send(1, 32'h08, 3'd2, 32'h0102_0304, 0, 0, "R7 word write");
      send(0, 32'h08, 3'd2, 0, 0, 32'h0102_0304, "R7 word read");
      send(1, 32'h08, 3'd0, 32'hFFFF_FFFF, 1, 0, "R7 byte refused");
      send(1, 32'h0A, 3'd1, 32'hFFFF_FFFF, 1, 0, "R7 half refused");
      send(0, 32'h09, 3'd0, 0, 1, 0, "R7 narrow read refused");
      send(0, 32'h08, 3'd2, 0, 0, 32'h0102_0304, "R7 register unchanged");

      repeat (2) @(posedge hclk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule